// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables from memory. A request names the address, whether the access is a write, and whether it comes from supervisor or user mode. The mode picks one of two root frame numbers. The walker first fetches a segment entry from the table at that root. It then fetches a page entry from the table that the segment entry points to. It returns the physical address with the read-only and cache-inhibit attributes, or it reports one of three fault classes.

When an access succeeds and the page entry lacks a status bit that the access should set, the walker stores the entry back once. The store sets the referenced bit, and on a write it also sets the modified bit. A mode whose translation is switched off returns the virtual address unchanged and does not touch memory. Memory is reached through a single word port that holds each request until it is acknowledged. Only one walk is in progress at a time.

Top module: `ptw_walker`

## Requirements
- R1: Segment entry fetch address = root frame * 4096 + VA[31:22] * 4. The root is `sup_root_i` when `req_super_i` = 1 and `usr_root_i` otherwise. Page entry fetch address = segment entry bits 31:12 * 4096 + VA[21:12] * 4.
- R2: On success, `pa_o` = page entry bits 31:12 concatenated with VA[11:0]. `ci_o` = page entry bit 6. `ro_o` = segment entry bit 2 OR page entry bit 2. Page entry bits 11:7 have no effect on the result.
- R3: A segment entry is usable only if bit 1 = 1, bit 3 = 1 and bits 11:4 = 0. Otherwise the walk ends with `fault_o` and `fault_kind_o` = 1, and no page entry is read.
- R4: A page entry with bit 0 = 0 ends the walk with `fault_kind_o` = 2 and no write-back.
- R5: A write whose combined read-only attribute (R2) is 1 ends the walk with `fault_kind_o` = 3 and no write-back.
- R6: A successful walk writes the page entry back exactly once when bit 3 = 0, or when the access is a write and bit 4 = 0. The stored word is the read word with bit 3 set, and on writes also bit 4 set. All other bits are unchanged. Otherwise no write occurs.
- R7: When the enable for the request's mode (`sup_xlate_en_i` or `usr_xlate_en_i`) is 0, the result is `pa_o` = VA, `ro_o` = 0, `ci_o` = 0 and `fault_kind_o` = 0, with no memory access.
- R8: `busy_o` rises on the edge that accepts a request and stays high up to and including the single cycle in which `done_o` or `fault_o` is high. It is low in the following cycle. A request presented while busy is ignored.
- R9: `mem_req_o` and its address, write enable and write data stay constant until `mem_ack_i`. Each access ends after one acknowledge.
- R10: After reset, `busy_o`, `done_o`, `fault_o` and `mem_req_o` are 0.
- R11: `fault_kind_o` is 0 whenever `done_o` is high and nonzero whenever `fault_o` is high. The codes are 1 for a table fault, 2 for a page fault and 3 for a protection fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request, taken when idle |
| req_va_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_super_i | input | 1 | Access is in supervisor mode |
| sup_root_i | input | 20 | Supervisor segment table frame |
| usr_root_i | input | 20 | User segment table frame |
| sup_xlate_en_i | input | 1 | Supervisor translation enable |
| usr_xlate_en_i | input | 1 | User translation enable |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle success pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_kind_o | output | 2 | Fault class code |
| pa_o | output | 32 | Physical address |
| ro_o | output | 1 | Read-only attribute |
| ci_o | output | 1 | Cache-inhibit attribute |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |

## Verification
Several rules are checked on every cycle by assertions. These are the memory request hold rule, the pairing of fault codes with the done and fault pulses, and the return of busy to low after a pulse. The assertions also check that a write-back changes only the status bits and only when one of them is missing, and that a protection fault comes only from a write. Other behaviour can be shown only by the bench's sweep. That sweep covers every combination of segment entry kind, page entry kind, mode and access direction against a memory model. It shows the correct table addresses, the physical address and attributes, the absence of the page read after a table fault, and the stored entry. Bypass per mode and rejection of requests while busy are shown by dedicated scenarios.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TABLE = 2'd1,
    FLT_PAGE  = 2'd2,
    FLT_PROT  = 2'd3
  } ptw_fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SEG, S_PAGE, S_WB, S_DONE, S_FAULT
  } ptw_state_e;

  localparam int SEG_VALID = 1;
  localparam int SEG_RO    = 2;
  localparam int SEG_ONE   = 3;
  localparam int SEG_ZLO   = 4;

  localparam int PG_VALID  = 0;
  localparam int PG_RO     = 2;
  localparam int PG_REF    = 3;
  localparam int PG_MOD    = 4;
  localparam int PG_CI     = 6;
endpackage

// File: rtl/ptw_seg_eval.sv
module ptw_seg_eval
  import ptw_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFF_W = 12
) (
  input  logic [W-1:0]       seg_i,
  output logic               ok_o,
  output logic               ro_o,
  output logic [W-OFF_W-1:0] pfn_o
);
  logic unused_seg;
  assign unused_seg = seg_i[0];

  // usable only when valid, marker bit one and reserved field zero
  assign ok_o  = seg_i[SEG_VALID] & seg_i[SEG_ONE] & ~|seg_i[OFF_W-1:SEG_ZLO];
  assign ro_o  = seg_i[SEG_RO];
  assign pfn_o = seg_i[W-1:OFF_W];
endmodule

// File: rtl/ptw_page_eval.sv
module ptw_page_eval
  import ptw_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFF_W = 12
) (
  input  logic [W-1:0]       pte_i,
  input  logic               write_i,
  input  logic               seg_ro_i,
  output logic               valid_o,
  output logic               ro_o,
  output logic               ci_o,
  output logic               prot_o,
  output logic               wb_need_o,
  output logic [W-1:0]       wb_data_o,
  output logic [W-OFF_W-1:0] pfn_o
);
  logic [W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[PG_REF] = 1'b1;
    set_mask[PG_MOD] = write_i;
  end

  assign valid_o   = pte_i[PG_VALID];
  assign ro_o      = seg_ro_i | pte_i[PG_RO];
  assign ci_o      = pte_i[PG_CI];
  assign prot_o    = valid_o & write_i & ro_o;
  assign wb_data_o = pte_i | set_mask;
  assign wb_need_o = valid_o & ~prot_o & (wb_data_o != pte_i);
  assign pfn_o     = pte_i[W-1:OFF_W];
endmodule

// File: rtl/ptw_addr_sel.sv
module ptw_addr_sel #(
  parameter int PFN_W  = 20,
  parameter int IDX_W  = 10,
  parameter int ENT_LG = 2
) (
  input  logic                          page_lvl_i,
  input  logic [PFN_W-1:0]              root_pfn_i,
  input  logic [PFN_W-1:0]              tbl_pfn_i,
  input  logic [IDX_W-1:0]              seg_idx_i,
  input  logic [IDX_W-1:0]              pg_idx_i,
  output logic [PFN_W+IDX_W+ENT_LG-1:0] addr_o
);
  localparam logic [ENT_LG-1:0] ENT_ZERO = '0;

  assign addr_o = page_lvl_i ? {tbl_pfn_i, pg_idx_i, ENT_ZERO}
                             : {root_pfn_i, seg_idx_i, ENT_ZERO};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [VA_W-1:0]           req_va_i,
  input  logic                      req_write_i,
  input  logic                      req_super_i,
  input  logic [VA_W-OFF_W-1:0]     sup_root_i,
  input  logic [VA_W-OFF_W-1:0]     usr_root_i,
  input  logic                      sup_xlate_en_i,
  input  logic                      usr_xlate_en_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      fault_o,
  output logic [1:0]                fault_kind_o,
  output logic [VA_W-1:0]           pa_o,
  output logic                      ro_o,
  output logic                      ci_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [VA_W-1:0]           mem_addr_o,
  output logic [VA_W-1:0]           mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [VA_W-1:0]           mem_rdata_i
);
  localparam int PFN_W = VA_W - OFF_W;
  localparam int IDX_W = OFF_W - ENT_LG;

  ptw_state_e        state_q;
  ptw_fault_e        kind_q;
  logic [VA_W-1:0]   va_q, pa_q, pte_q, wb_q;
  logic [PFN_W-1:0]  root_q, tbl_q;
  logic              wr_q, seg_ro_q, ro_q, ci_q;

  logic              seg_ok, seg_ro;
  logic [PFN_W-1:0]  seg_pfn, pg_pfn;
  logic              pg_valid, pg_ro, pg_ci, pg_prot, pg_wb_need;
  logic [VA_W-1:0]   pg_wb_data;
  logic              xlate_en;

  ptw_seg_eval #(.W(VA_W), .OFF_W(OFF_W)) u_seg (
    .seg_i (mem_rdata_i),
    .ok_o  (seg_ok),
    .ro_o  (seg_ro),
    .pfn_o (seg_pfn)
  );

  ptw_page_eval #(.W(VA_W), .OFF_W(OFF_W)) u_page (
    .pte_i     (mem_rdata_i),
    .write_i   (wr_q),
    .seg_ro_i  (seg_ro_q),
    .valid_o   (pg_valid),
    .ro_o      (pg_ro),
    .ci_o      (pg_ci),
    .prot_o    (pg_prot),
    .wb_need_o (pg_wb_need),
    .wb_data_o (pg_wb_data),
    .pfn_o     (pg_pfn)
  );

  ptw_addr_sel #(.PFN_W(PFN_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_addr (
    .page_lvl_i (state_q != S_SEG),
    .root_pfn_i (root_q),
    .tbl_pfn_i  (tbl_q),
    .seg_idx_i  (va_q[VA_W-1 -: IDX_W]),
    .pg_idx_i   (va_q[OFF_W+IDX_W-1 -: IDX_W]),
    .addr_o     (mem_addr_o)
  );

  assign xlate_en = req_super_i ? sup_xlate_en_i : usr_xlate_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      kind_q   <= FLT_NONE;
      va_q     <= '0;
      pa_q     <= '0;
      pte_q    <= '0;
      wb_q     <= '0;
      root_q   <= '0;
      tbl_q    <= '0;
      wr_q     <= 1'b0;
      seg_ro_q <= 1'b0;
      ro_q     <= 1'b0;
      ci_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q   <= req_va_i;
          wr_q   <= req_write_i;
          root_q <= req_super_i ? sup_root_i : usr_root_i;
          kind_q <= FLT_NONE;
          if (xlate_en) begin
            state_q <= S_SEG;
          end else begin
            pa_q    <= req_va_i;
            ro_q    <= 1'b0;
            ci_q    <= 1'b0;
            state_q <= S_DONE;
          end
        end
        S_SEG: if (mem_ack_i) begin
          if (!seg_ok) begin
            kind_q  <= FLT_TABLE;
            state_q <= S_FAULT;
          end else begin
            tbl_q    <= seg_pfn;
            seg_ro_q <= seg_ro;
            state_q  <= S_PAGE;
          end
        end
        S_PAGE: if (mem_ack_i) begin
          pte_q <= mem_rdata_i;
          wb_q  <= pg_wb_data;
          if (!pg_valid) begin
            kind_q  <= FLT_PAGE;
            state_q <= S_FAULT;
          end else if (pg_prot) begin
            kind_q  <= FLT_PROT;
            state_q <= S_FAULT;
          end else begin
            pa_q    <= {pg_pfn, va_q[OFF_W-1:0]};
            ro_q    <= pg_ro;
            ci_q    <= pg_ci;
            state_q <= pg_wb_need ? S_WB : S_DONE;
          end
        end
        S_WB:    if (mem_ack_i) state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign fault_o      = (state_q == S_FAULT);
  assign fault_kind_o = kind_q;
  assign pa_o         = pa_q;
  assign ro_o         = ro_q;
  assign ci_o         = ci_q;
  assign mem_req_o    = (state_q == S_SEG) || (state_q == S_PAGE) || (state_q == S_WB);
  assign mem_we_o     = (state_q == S_WB);
  assign mem_wdata_o  = wb_q;

  // write-back may touch only the two status bits
  logic [VA_W-1:0] stat_mask;
  always_comb begin
    stat_mask = '0;
    stat_mask[PG_REF] = 1'b1;
    stat_mask[PG_MOD] = 1'b1;
  end

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r8_idle_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !busy_o);

  a_r11_done_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_kind_o == FLT_NONE);

  a_r11_fault_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_kind_o != FLT_NONE);

  a_r5_prot_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && fault_kind_o == FLT_PROT |-> wr_q);

  a_r6_wb_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (((mem_wdata_o ^ pte_q) & ~stat_mask) == '0) && mem_wdata_o[PG_REF]);

  a_r6_wb_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!pte_q[PG_REF] || (wr_q && !pte_q[PG_MOD])));

  a_r6_wb_mod_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !wr_q |-> mem_wdata_o[PG_MOD] == pte_q[PG_MOD]);

  a_r4_no_wb_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !$past(mem_we_o));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_super = 0;
  logic [31:0] req_va = '0;
  logic [19:0] sup_root = 20'h00040, usr_root = 20'h00050;
  logic        sup_en = 1, usr_en = 1;
  logic        busy, done, fault, ro, ci;
  logic [1:0]  kind;
  logic [31:0] pa;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, errors = 0;
  int rcount = 0, wcount = 0;
  logic [31:0] mem [logic [31:0]];

  always #5 clk = ~clk;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_write_i(req_write),
    .req_super_i(req_super), .sup_root_i(sup_root), .usr_root_i(usr_root),
    .sup_xlate_en_i(sup_en), .usr_xlate_en_i(usr_en),
    .busy_o(busy), .done_o(done), .fault_o(fault), .fault_kind_o(kind),
    .pa_o(pa), .ro_o(ro), .ci_o(ci),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: acknowledges one cycle after a request is seen
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 0;
    else if (mem_req && rst_n) begin
      mem_ack = 1;
      if (mem_we) begin mem[mem_addr] = mem_wdata; wcount++; end
      else begin mem_rdata = rd(mem_addr); rcount++; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // walk results
  bit          g_done, g_fault, g_busy_ok, g_idle_after;
  logic [1:0]  g_kind;
  logic [31:0] g_pa;
  bit          g_ro, g_ci;
  int          g_rd, g_wr;

  task automatic walk(input logic [31:0] va, input bit wr, input bit sup, input bit spam);
    int r0, w0, n;
    r0 = rcount; w0 = wcount;
    @(negedge clk);
    req_valid = 1; req_va = va; req_write = wr; req_super = sup;
    @(negedge clk);
    if (spam) begin req_va = ~va; req_write = ~wr; req_super = ~sup; end
    else req_valid = 0;
    n = 0; g_busy_ok = 1;
    while (!(done || fault) && n < 64) begin
      if (!busy) g_busy_ok = 0;
      @(negedge clk); n++;
    end
    if (!busy) g_busy_ok = 0;
    g_done = done; g_fault = fault; g_kind = kind;
    g_pa = pa; g_ro = ro; g_ci = ci;
    req_valid = 0;
    @(negedge clk);
    g_idle_after = !busy && !done && !fault;
    g_rd = rcount - r0; g_wr = wcount - w0;
  endtask

  function automatic logic [9:0]  seg_idx(input int s); return 10'(s * 37 + 3); endfunction
  function automatic logic [9:0]  pg_idx(input int p);  return 10'(p * 91 + 5); endfunction
  function automatic logic [19:0] tbl_frame(input int m, input int s); return 20'h00100 + 20'(m * 16 + s); endfunction
  function automatic logic [19:0] pg_frame(input int m, input int s, input int p);
    return 20'h03000 + 20'(m * 256 + s * 16 + p);
  endfunction
  function automatic logic [11:0] seg_flags(input int s);
    case (s)
      0: return 12'h00A;
      1: return 12'h00E;
      2: return 12'h008;
      3: return 12'h002;
      default: return 12'h01A;
    endcase
  endfunction
  function automatic logic [11:0] pg_flags(input int p);
    case (p)
      0: return 12'h000;
      1: return 12'h001;
      2: return 12'h005;
      3: return 12'h009;
      4: return 12'h019;
      5: return 12'h041;
      6: return 12'hF89;
      default: return 12'h00D;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // tables for both modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 5; s++) begin
        logic [19:0] root;
        root = m ? sup_root : usr_root;
        mem[{root, seg_idx(s), 2'b00}] = {tbl_frame(m, s), seg_flags(s)};
      end

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !fault && !mem_req, "R10 reset idle", {busy, done, fault, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req, "R10 idle after release", {busy, mem_req}, 0);

    // R1..R6, R8, R11 sweep
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 5; s++)
        for (int p = 0; p < 8; p++)
          for (int w = 0; w < 2; w++) begin
            logic [31:0] va, ste, pte0, pte_addr, exp_pte;
            logic [11:0] off;
            logic [1:0]  ek;
            bit          seg_ok, eror, exp_wb;
            int          erd;
            off = 12'((s * p * 97 + 13 + w * 5) & 12'hFFF);
            va = {seg_idx(s), pg_idx(p), off};
            pte_addr = {tbl_frame(m, s), pg_idx(p), 2'b00};
            pte0 = {pg_frame(m, s, p), pg_flags(p)};
            mem[pte_addr] = pte0;
            ste = {tbl_frame(m, s), seg_flags(s)};
            seg_ok = ste[1] && ste[3] && (ste[11:4] == 0);
            eror = ste[2] | pte0[2];
            exp_pte = pte0;
            exp_wb = 0;
            if (!seg_ok) begin ek = 2'd1; erd = 1; end
            else if (!pte0[0]) begin ek = 2'd2; erd = 2; end
            else if (w == 1 && eror) begin ek = 2'd3; erd = 2; end
            else begin
              ek = 2'd0; erd = 2;
              exp_pte = pte0 | 32'h8 | (w == 1 ? 32'h10 : 32'h0);
              exp_wb = (exp_pte != pte0);
            end
            walk(va, w[0], m[0], (s + p) % 5 == 0);

            chk(g_busy_ok && g_idle_after, "R8 busy window", {g_busy_ok, g_idle_after}, 2'b11);
            chk(g_done == (ek == 0) && g_fault == (ek != 0), "R11 pulse kind", {g_done, g_fault}, {ek == 0, ek != 0});
            chk(g_kind == ek, ek == 1 ? "R3 table fault" : ek == 2 ? "R4 page fault" : ek == 3 ? "R5 prot fault" : "R11 no fault", g_kind, ek);
            chk(g_rd == erd, "R1 R3 read count", g_rd, erd);
            chk(g_wr == int'(exp_wb), "R6 write count", g_wr, exp_wb);
            chk(rd(pte_addr) == exp_pte, "R6 stored entry", rd(pte_addr), exp_pte);
            if (ek == 0) begin
              chk(g_pa == {pg_frame(m, s, p), off}, "R1 R2 physical address", g_pa, {pg_frame(m, s, p), off});
              chk(g_ro == eror, "R2 read-only", g_ro, eror);
              chk(g_ci == pte0[6], "R2 cache-inhibit", g_ci, pte0[6]);
            end
          end

    // R7 bypass per mode
    for (int m = 0; m < 2; m++) begin
      sup_en = (m == 0); usr_en = (m == 1);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] va;
        va = 32'h9E37_79B9 * (k + 1) + 32'(m);
        walk(va, k[0], m[0], k == 3);
        chk(g_done && !g_fault && g_kind == 0, "R7 bypass ok", {g_done, g_fault, g_kind}, 4'b1000);
        chk(g_pa == va && !g_ro && !g_ci, "R7 bypass pa", g_pa, va);
        chk(g_rd == 0 && g_wr == 0, "R7 bypass no memory", g_rd + g_wr, 0);
        chk(g_busy_ok && g_idle_after, "R8 bypass busy", {g_busy_ok, g_idle_after}, 2'b11);
      end
      // other mode still walks: segment 0, page 3 (referenced, readable)
      walk({seg_idx(0), pg_idx(3), 12'h123}, 1'b0, ~m[0], 1'b0);
      chk(g_done && g_rd == 2, "R7 other mode walks", g_rd, 2);
    end
    sup_en = 1; usr_en = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule